// File: doc/BRIEF.md
# DDS Sine Stimulus with First-Order Sigma-Delta Output

This block is an on-chip analogue test source. A direct digital synthesiser builds one signed digital sample per sample-rate tick from a phase accumulator. The sample is scaled by a programmable amplitude and shifted to an unsigned code. A first-order one-bit sigma-delta modulator then turns that code into a bitstream. An external low-pass filter recovers the analogue waveform from the bitstream and feeds it to the converter under test.

A processor's stimulus instruction drives the block. While the instruction holds `stim_en` high, the generator runs. The operands of the instruction (tuning word, amplitude, rate divider and waveform code) are captured once, when the generator starts. When `stim_en` is low, the generator is parked: the phase and the integrator are cleared, and the bitstream shows a mid-scale pattern of alternating ones and zeros.

Top module: `dds_sd_stim`

## Requirements
- R1: While the generator is idle, `samp_stb` stays low and `bit_out` inverts on every clock. The generator is idle from the clock after `stim_en` is seen low, and also after reset.
- R2: Once running, `samp_stb` is a one-clock pulse that repeats every `rate_div`+1 clocks. `rate_div` = 0 gives a pulse on every clock.
- R3: `tune_word`, `amp_scale`, `rate_div` and `wave_sel` are captured on the clock at which `stim_en` is first seen high. Any change to them while the generator runs has no effect on the strobe rate or on the bitstream.
- R4: The phase accumulator starts at zero when the generator starts. It adds the captured tuning word once per strobe and wraps modulo 2^24.
- R5: Waveform code 0 (sine) uses the top two phase bits as the quadrant and the next 6 bits as the index i into a 64-entry quarter table. Entry i is round(2047·sin(i·π/128)). Odd quadrants read entry 63−i, and quadrants 2 and 3 negate the value.
- R6: The other waveform codes work as follows. Code 1 (square) gives +2047 when the phase MSB is 0 and −2047 when it is 1. Code 2 (triangle) takes the top 12 phase bits p. It folds them to f = p[10:0], or to the inverse of p[10:0] when p[11] = 1, and outputs 2f − 2048. Code 3 (ramp) outputs p − 2048.
- R7: The signed 12-bit sample s is multiplied by the 8-bit amplitude a and arithmetically shifted right by 8 (floor). Then 2048 is added to give the unsigned modulator input u.
- R8: The modulator integrates u minus 4096 times the previous output bit. It emits the integrator's top bit on every clock. Over any L clocks of constant u, the count of ones is within 2 of u·L/4096.
- R9: Dropping `stim_en` clears the phase and the integrator. Restarting the generator with the same operands reproduces the same sequence of samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stim_en | input | 1 | Run request from the stimulus instruction |
| tune_word | input | 24 | Phase increment per sample |
| amp_scale | input | 8 | Amplitude multiplier, unsigned, 255 is about full scale |
| rate_div | input | 16 | Sample period minus one, in clocks |
| wave_sel | input | 2 | Waveform code: 0 sine, 1 square, 2 triangle, 3 ramp |
| bit_out | output | 1 | One-bit modulated stream |
| samp_stb | output | 1 | Pulse marking each new sample |

## Verification
The properties assume that `rst` is held for at least one clock before use. They also assume that the operand inputs matter only on the clock where `stim_en` rises. The bench respects both: it holds reset for several clocks, and it changes the operands freely while the generator runs, which probes the capture rule directly. Bitstream checks count ones over whole sample periods. Each count starts three clocks after a strobe, the path from strobe to output bit, and is compared with a tolerance of two. This absorbs the integrator residue left over from the previous period.

// File: rtl/dds_sd_pkg.sv
package dds_sd_pkg;

   typedef enum logic [1:0] {
      WAVE_SINE   = 2'd0,
      WAVE_SQUARE = 2'd1,
      WAVE_TRI    = 2'd2,
      WAVE_RAMP   = 2'd3
   } wave_e;

   localparam real PI_R = 3.14159265358979323846;

   // quarter-wave sine entry i of n, scaled to peak, rounded
   function automatic int qsine(input int i, input int n, input int peak);
      real ang;
      ang = real'(i) * PI_R / (2.0 * real'(n));
      return $rtoi(real'(peak) * $sin(ang) + 0.5);
   endfunction

endpackage

// File: rtl/dds_rate_tick.sv
module dds_rate_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             active,
   input  logic [DIV_W-1:0] div_ld,
   input  logic [DIV_W-1:0] div_rl,
   output logic             stb
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         stb   <= 1'b0;
      end else if (load) begin
         cnt_q <= div_ld;
         stb   <= 1'b0;
      end else if (!active) begin
         stb   <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q <= div_rl;
         stb   <= 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
         stb   <= 1'b0;
      end
   end
endmodule

// File: rtl/dds_wave_gen.sv
module dds_wave_gen
   import dds_sd_pkg::*;
#(
   parameter int PH_W   = 24,
   parameter int TBL_AW = 6,
   parameter int SAMP_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     run,
   input  logic                     step,
   input  logic [PH_W-1:0]          tw,
   input  wave_e                    wave,
   output logic [PH_W-1:0]          phase_o,
   output logic signed [SAMP_W-1:0] wave_o
);
   localparam int TBL_N = 1 << TBL_AW;
   localparam int PEAK  = (1 << (SAMP_W-1)) - 1;
   localparam logic signed [SAMP_W-1:0] PEAK_S = SAMP_W'(PEAK);

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (rst || !run)  ph_q <= '0;
      else if (step)    ph_q <= ph_q + tw;
   end
   assign phase_o = ph_q;

   // quarter-wave table, computed at elaboration
   logic signed [SAMP_W-1:0] qtab [TBL_N];
   for (genvar gi = 0; gi < TBL_N; gi++) begin : g_tab
      localparam int V = qsine(gi, TBL_N, PEAK);
      assign qtab[gi] = SAMP_W'(V);
   end

   logic [1:0]               quad;
   logic [TBL_AW-1:0]        idx;
   logic [SAMP_W-1:0]        top;
   logic [SAMP_W-2:0]        fold;
   logic signed [SAMP_W-1:0] mag, s_sine, s_sq, s_tri, s_ramp;

   always_comb begin
      quad   = ph_q[PH_W-1 -: 2];
      idx    = ph_q[PH_W-3 -: TBL_AW];
      top    = ph_q[PH_W-1 -: SAMP_W];
      mag    = quad[0] ? qtab[~idx] : qtab[idx];
      s_sine = quad[1] ? -mag : mag;
      s_sq   = quad[1] ? -PEAK_S : PEAK_S;
      fold   = top[SAMP_W-1] ? ~top[SAMP_W-2:0] : top[SAMP_W-2:0];
      s_tri  = {~fold[SAMP_W-2], fold[SAMP_W-3:0], 1'b0};
      s_ramp = {~top[SAMP_W-1], top[SAMP_W-2:0]};
      unique case (wave)
         WAVE_SINE:   wave_o = s_sine;
         WAVE_SQUARE: wave_o = s_sq;
         WAVE_TRI:    wave_o = s_tri;
         default:     wave_o = s_ramp;
      endcase
   end
endmodule

// File: rtl/dds_amp_offset.sv
module dds_amp_offset #(
   parameter int SAMP_W = 12,
   parameter int AMP_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     run,
   input  logic signed [SAMP_W-1:0] wave,
   input  logic [AMP_W-1:0]         amp,
   output logic [SAMP_W-1:0]        samp
);
   localparam int PW = SAMP_W + AMP_W + 1;
   localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W-1);

   logic signed [PW-1:0]     prod;
   logic signed [SAMP_W-1:0] scl;
   logic [SAMP_W-1:0]        ucode;

   always_comb begin
      prod  = PW'(wave) * $signed({1'b0, amp});
      scl   = SAMP_W'(prod >>> AMP_W);
      ucode = {~scl[SAMP_W-1], scl[SAMP_W-2:0]};
   end

   always_ff @(posedge clk) begin
      if (rst)       samp <= MID;
      else if (run)  samp <= ucode;
      else           samp <= MID;
   end
endmodule

// File: rtl/sd_mod_first.sv
module sd_mod_first #(
   parameter int SAMP_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic [SAMP_W-1:0] u,
   output logic              bit_o
);
   localparam int IW = SAMP_W + 1;
   localparam logic [IW-1:0] FULL = IW'(1) << SAMP_W;

   logic [IW-1:0] integ_q;
   logic          tog_q;
   logic [IW-1:0] fb;

   assign fb = integ_q[SAMP_W] ? FULL : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         integ_q <= '0;
         tog_q   <= 1'b0;
      end else if (!run) begin
         integ_q <= '0;
         tog_q   <= ~tog_q;
      end else begin
         integ_q <= integ_q + {1'b0, u} - fb;
      end
   end

   assign bit_o = run ? integ_q[SAMP_W] : tog_q;
endmodule

// File: rtl/dds_sd_stim.sv
module dds_sd_stim
   import dds_sd_pkg::*;
#(
   parameter int PH_W   = 24,
   parameter int TBL_AW = 6,
   parameter int SAMP_W = 12,
   parameter int AMP_W  = 8,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stim_en,
   input  logic [PH_W-1:0]   tune_word,
   input  logic [AMP_W-1:0]  amp_scale,
   input  logic [DIV_W-1:0]  rate_div,
   input  logic [1:0]        wave_sel,
   output logic              bit_out,
   output logic              samp_stb
);
   localparam int CFG_W = 2 + PH_W + AMP_W + DIV_W;

   if (SAMP_W < 4) begin : g_bad_samp
      $error("SAMP_W must be at least 4");
   end
   if (TBL_AW < 2) begin : g_bad_tbl
      $error("TBL_AW must be at least 2");
   end
   if (PH_W < SAMP_W || PH_W < TBL_AW + 2) begin : g_bad_ph
      $error("PH_W too narrow for table or sample width");
   end

   logic              run_q, start;
   logic [PH_W-1:0]   tw_q;
   logic [AMP_W-1:0]  amp_q;
   logic [DIV_W-1:0]  div_q;
   wave_e             wave_q;
   logic [PH_W-1:0]   phase;
   logic signed [SAMP_W-1:0] wave_s;
   logic [SAMP_W-1:0] samp;
   logic [CFG_W-1:0]  cfg_cat;

   assign start   = stim_en && !run_q;
   assign cfg_cat = {wave_q, tw_q, amp_q, div_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         tw_q   <= '0;
         amp_q  <= '0;
         div_q  <= '0;
         wave_q <= WAVE_SINE;
      end else begin
         run_q <= stim_en;
         if (start) begin
            tw_q   <= tune_word;
            amp_q  <= amp_scale;
            div_q  <= rate_div;
            wave_q <= wave_e'(wave_sel);
         end
      end
   end

   dds_rate_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst    (rst),
      .load   (start),
      .active (stim_en && run_q),
      .div_ld (rate_div),
      .div_rl (div_q),
      .stb    (samp_stb)
   );

   dds_wave_gen #(.PH_W(PH_W), .TBL_AW(TBL_AW), .SAMP_W(SAMP_W)) u_wave (
      .clk     (clk),
      .rst     (rst),
      .run     (run_q),
      .step    (samp_stb),
      .tw      (tw_q),
      .wave    (wave_q),
      .phase_o (phase),
      .wave_o  (wave_s)
   );

   dds_amp_offset #(.SAMP_W(SAMP_W), .AMP_W(AMP_W)) u_amp (
      .clk  (clk),
      .rst  (rst),
      .run  (run_q),
      .wave (wave_s),
      .amp  (amp_q),
      .samp (samp)
   );

   sd_mod_first #(.SAMP_W(SAMP_W)) u_mod (
      .clk   (clk),
      .rst   (rst),
      .run   (run_q),
      .u     (samp),
      .bit_o (bit_out)
   );
endmodule

// File: rtl/dds_sd_stim_chk.sv
module dds_sd_stim_chk #(
   parameter int PH_W   = 24,
   parameter int SAMP_W = 12,
   parameter int CFG_W  = 50
) (
   input logic              clk,
   input logic              rst,
   input logic              stim_en,
   input logic              bit_out,
   input logic              samp_stb,
   input logic              running,
   input logic [PH_W-1:0]   phase,
   input logic [SAMP_W-1:0] samp,
   input logic [CFG_W-1:0]  cfg_cat
);
   localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W-1);

   assert_idle_toggle_R1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(stim_en) && !$past(stim_en, 2)) |-> (bit_out != $past(bit_out)));

   assert_stb_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
      samp_stb |-> $past(stim_en));

   assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
      (running && $past(running)) |-> $stable(cfg_cat));

   assert_phase_steps_R4: assert property (@(posedge clk) disable iff (rst)
      (running && $past(running) && !$past(samp_stb)) |-> $stable(phase));

   assert_idle_phase_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(running)) |-> (phase == '0));

   assert_idle_midscale_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(stim_en, 2)) |-> (samp == MID));
endmodule

bind dds_sd_stim dds_sd_stim_chk #(
   .PH_W(PH_W), .SAMP_W(SAMP_W), .CFG_W(CFG_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .stim_en  (stim_en),
   .bit_out  (bit_out),
   .samp_stb (samp_stb),
   .running  (run_q),
   .phase    (phase),
   .samp     (samp),
   .cfg_cat  (cfg_cat)
);

// File: tb/tb_dds_sd_stim.sv
module tb_dds_sd_stim;
   localparam int PH_W = 24, SAMP_W = 12, AMP_W = 8, DIV_W = 16;
   localparam logic [PH_W-1:0] TW_HALF = 24'h800000;
   localparam logic [PH_W-1:0] TW_QTR  = 24'h400000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic stim_en = 1'b0;
   logic [PH_W-1:0]  tune_word = '0;
   logic [AMP_W-1:0] amp_scale = '0;
   logic [DIV_W-1:0] rate_div = '0;
   logic [1:0]       wave_sel = '0;
   logic bit_out, samp_stb;

   always #10 clk = ~clk;

   dds_sd_stim dut (
      .clk(clk), .rst(rst), .stim_en(stim_en), .tune_word(tune_word),
      .amp_scale(amp_scale), .rate_div(rate_div), .wave_sel(wave_sel),
      .bit_out(bit_out), .samp_stb(samp_stb)
   );

   typedef struct { int u; string tag; } exp_t;
   exp_t sb[$];
   int   checks = 0, failures = 0;
   int   win_len = 1024;
   int   mon_cnt = 0;
   bit   mon_seen = 1'b0;
   logic [3:0] mon_dly = '0;
   exp_t mon_e;
   real  mon_ev;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int uval(input int s, input int a);
      return ((s * a) >>> 8) + 2048;
   endfunction

   function automatic int tq(input int i);
      return $rtoi(2047.0 * $sin(real'(i) * 3.14159265358979 / 128.0) + 0.5);
   endfunction

   // monitor: counts ones per sample period, aligned 3 clocks after each strobe
   initial begin
      forever begin
         @(posedge clk); #2;
         if (!stim_en) begin
            mon_cnt = 0; mon_seen = 1'b0; mon_dly = '0;
         end else begin
            mon_dly = {mon_dly[2:0], samp_stb};
            if (mon_dly[3]) begin
               if (mon_seen && sb.size() > 0) begin
                  mon_e  = sb.pop_front();
                  mon_ev = real'(mon_e.u) * real'(win_len) / 4096.0;
                  check((real'(mon_cnt) - mon_ev <= 2.0) && (mon_ev - real'(mon_cnt) <= 2.0),
                        mon_e.tag, mon_cnt, $rtoi(mon_ev + 0.5));
               end
               mon_cnt = 0; mon_seen = 1'b1;
            end
            mon_cnt += int'(bit_out);
         end
      end
   end

   // driver: programs a case, queues expected per-period codes, waits for drain
   task automatic run_case(input logic [1:0] w, input logic [PH_W-1:0] tw, input int amp,
                           input int div, input int e[4], input int n, input string tag,
                           input bit scramble);
      @(negedge clk);
      wave_sel = w; tune_word = tw; amp_scale = AMP_W'(amp); rate_div = DIV_W'(div);
      win_len = div + 1;
      for (int i = 0; i < n; i++) sb.push_back('{e[i], tag});
      stim_en = 1'b1;
      if (scramble) begin
         repeat (50) @(negedge clk);
         wave_sel = ~w; tune_word = ~tw; amp_scale = 8'd3; rate_div = 16'd3;
      end
      while (sb.size() > 0) @(negedge clk);
      stim_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_toggle(input int n, input string tag);
      logic prev;
      @(negedge clk); prev = bit_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(bit_out != prev, tag, int'(bit_out), int'(~prev));
         check(samp_stb == 1'b0, tag, int'(samp_stb), 0);
         prev = bit_out;
      end
   endtask

   task automatic check_period(input int div, input string tag);
      int gap;
      @(negedge clk);
      rate_div = DIV_W'(div); stim_en = 1'b1;
      while (!samp_stb) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         gap = 0;
         do begin @(negedge clk); gap++; end while (!samp_stb && gap < 100);
         check(gap == div + 1, tag, gap, div + 1);
      end
      stim_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int t63;
      t63 = tq(63);
      repeat (5) @(negedge clk);
      rst = 1'b0;
      // R1: reset/idle state
      check_toggle(6, "R1 idle after reset");
      // R2: strobe period
      check_period(5, "R2 period div=5");
      check_period(0, "R2 period div=0");
      // R5: sine at phase zero is mid-scale; R8 density
      run_case(2'd0, '0, 255, 1023, '{2048, 2048, 2048, 0}, 3, "R5 sine phase0", 1'b0);
      // R4: half-turn steps, square alternates
      run_case(2'd1, TW_HALF, 255, 1023, '{8, 4087, 8, 4087}, 4, "R4 square half-turn", 1'b0);
      // R5: quarter-turn sine
      run_case(2'd0, TW_QTR, 255, 1023,
               '{uval(t63, 255), 2048, uval(-t63, 255), 2048}, 4, "R5 sine quarter-turn", 1'b0);
      // R6: ramp and triangle
      run_case(2'd3, '0, 128, 1023, '{1024, 1024, 0, 0}, 2, "R6 ramp phase0", 1'b0);
      run_case(2'd3, TW_HALF, 255, 1023, '{2048, 8, 0, 0}, 2, "R6 ramp half-turn", 1'b0);
      run_case(2'd2, TW_HALF, 255, 1023, '{uval(2046, 255), 8, 0, 0}, 2, "R6 triangle", 1'b0);
      // R7: amplitude scaling with floor
      run_case(2'd1, TW_HALF, 0, 1023, '{2048, 2048, 0, 0}, 2, "R7 zero amplitude", 1'b0);
      run_case(2'd1, TW_HALF, 128, 1023, '{1024, 3071, 0, 0}, 2, "R7 half amplitude", 1'b0);
      // R8: modulator density at a third code
      run_case(2'd1, '0, 64, 1023, '{2559, 2559, 0, 0}, 2, "R8 density", 1'b0);
      // R3: operands changed mid-run are ignored
      run_case(2'd1, '0, 255, 1023, '{4087, 4087, 4087, 0}, 3, "R3 operands frozen", 1'b1);
      // R9: disable clears state; restart repeats sequence
      run_case(2'd1, TW_HALF, 255, 1023, '{8, 4087, 0, 0}, 2, "R9 first run", 1'b0);
      check_toggle(6, "R1 idle after disable");
      run_case(2'd1, TW_HALF, 255, 1023, '{8, 4087, 0, 0}, 2, "R9 restart", 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule